// File: doc/BRIEF.md
# Millisecond Elapsed-Time Counter

This block keeps a 32-bit count of elapsed milliseconds and exposes it on a simple register bus. A free-running divider in a separate reference clock domain (24 MHz nominal) produces a 1 kHz tick. That tick is carried into the bus clock domain by a toggle synchronizer, and there it advances the count by one. Because the tick comes only from the reference clock, the millisecond rate stays the same when the bus clock changes frequency.

Software can read the count at any time. It can load a new starting value, or change individual bits through three alias addresses that OR, AND-NOT or XOR the write data into the count. The count is not retained: a reset returns it to zero. Once it reaches its full range it rolls over to zero, which takes roughly 49.7 days.

Top module: `msc_ms_counter`

## Requirements
- R1: After bus reset the count is zero, and a read of offset 0x020 returns 0.
- R2: The count advances by exactly one for each tick. A tick is produced once every DIV_CYCLES reference clock cycles, with a default of 24000, which gives 1 kHz from 24 MHz.
- R3: The spacing between increments depends only on the reference clock: it equals DIV_CYCLES reference periods regardless of the bus clock, and each tick gives exactly one increment.
- R4: A write to offset 0x020 replaces the count with the write data.
- R5: A write to offset 0x024 ORs the write data into the count.
- R6: A write to offset 0x028 clears the count bits that are set in the write data.
- R7: A write to offset 0x02C inverts the count bits that are set in the write data.
- R8: An increment from 0xFFFFFFFF gives 0x00000000.
- R9: When a write and a tick fall in the same bus cycle, the write result is stored and that tick is lost.
- R10: A read of any of the four offsets 0x020, 0x024, 0x028 and 0x02C returns the current count.
- R11: A read of any other offset returns 0, and a write to any other offset leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Bus-domain synchronous reset, active high |
| ref_clk | input | 1 | Reference clock (24 MHz nominal) |
| ref_rst | input | 1 | Reference-domain synchronous reset, active high |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from offset and count |

## Verification
The assertions assume that the bus clock runs at least several times faster than the tick rate, so that two tick pulses never arrive in consecutive bus cycles. They also assume that both resets are applied together, so the synchronizer never sees a stale toggle level. The bench satisfies both conditions: its reference clock is 25 MHz against a 200 MHz bus clock, with a small divider, which puts 64 bus cycles between ticks, and it releases both resets at the same time. Every read-modify-write test starts just after an observed increment, so it runs in a quiet window. The one exception is the collision test, which deliberately places a write on the cycle of the next tick.

// File: rtl/msc_pkg.sv
package msc_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_LOAD = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_SET  = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_CLR  = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_TOG  = 8'h2C;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD,
        OP_SET,
        OP_CLR,
        OP_TOG
    } alias_e;

    typedef struct packed {
        logic              valid;
        alias_e            op;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic alias_e decode_alias(input logic [ADDR_W-1:0] a);
        alias_e r;
        case (a)
            OFF_LOAD: r = OP_LOAD;
            OFF_SET:  r = OP_SET;
            OFF_CLR:  r = OP_CLR;
            OFF_TOG:  r = OP_TOG;
            default:  r = OP_NONE;
        endcase
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] apply_op(
        input alias_e            op,
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] d
    );
        logic [DATA_W-1:0] r;
        case (op)
            OP_LOAD: r = d;
            OP_SET:  r = cur | d;
            OP_CLR:  r = cur & ~d;
            OP_TOG:  r = cur ^ d;
            default: r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/msc_tick_gen.sv
module msc_tick_gen #(
    parameter int DIV_CYCLES = 24000
) (
    input  logic ref_clk,
    input  logic ref_rst,
    output logic tick_tgl
);
    localparam int DW = (DIV_CYCLES > 2) ? $clog2(DIV_CYCLES) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV_CYCLES - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge ref_clk) begin
        if (ref_rst) begin
            div_q    <= '0;
            tick_tgl <= 1'b0;
        end else if (div_q == LAST) begin
            div_q    <= '0;
            tick_tgl <= ~tick_tgl;
        end else begin
            div_q    <= div_q + 1'b1;
        end
    end

    // R2: the toggle flips once per divider period
    a_r2_toggle_at_wrap: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (div_q == LAST) |=> (div_q == '0) && (tick_tgl != $past(tick_tgl)));
    a_r2_toggle_hold: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (div_q != LAST) |=> $stable(tick_tgl));

endmodule

// File: rtl/msc_tick_sync.sv
module msc_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_async,
    output logic tick
);
    logic [STAGES:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-1:0], tgl_async};
    end

    assign tick = sync_q[STAGES] ^ sync_q[STAGES-1];

    // R3: each toggle gives a single one-cycle pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/msc_count_reg.sv
module msc_count_reg
    import msc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  wr_req_t           req,
    output logic [DATA_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (req.valid)  cnt <= apply_op(req.op, cnt, req.data);
        else if (tick)       cnt <= cnt + 1'b1;
    end

    // R1: reset clears the count
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (cnt == '0));
    // R2: a tick without a write advances by one (R8 wraps naturally)
    a_r2_increment: assert property (@(posedge clk) disable iff (rst)
        (tick && !req.valid) |=> (cnt == $past(cnt) + 1'b1));
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !req.valid) |=> $stable(cnt));
    // R9: a write wins over a coincident tick
    a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
        (req.valid && tick) |=> (cnt == apply_op($past(req.op), $past(cnt), $past(req.data))));

endmodule

// File: rtl/msc_ms_counter.sv
module msc_ms_counter
    import msc_pkg::*;
#(
    parameter int DIV_CYCLES  = 24000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_clk,
    input  logic              ref_rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              tgl;
    logic              tick;
    alias_e            hit;
    wr_req_t           req;
    logic [DATA_W-1:0] cnt;

    msc_tick_gen #(.DIV_CYCLES(DIV_CYCLES)) u_gen (
        .ref_clk  (ref_clk),
        .ref_rst  (ref_rst),
        .tick_tgl (tgl)
    );

    msc_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .tgl_async (tgl),
        .tick      (tick)
    );

    always_comb begin
        hit       = decode_alias(bus_addr);
        req.valid = bus_sel && bus_wr && (hit != OP_NONE);
        req.op    = hit;
        req.data  = bus_wdata;
        bus_rdata = (bus_sel && hit != OP_NONE) ? cnt : '0;
    end

    msc_count_reg u_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .req  (req),
        .cnt  (cnt)
    );

    // R11: an unmapped write leaves the count alone
    a_r11_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && hit == OP_NONE && !tick) |=> $stable(cnt));

endmodule

// File: tb/tb_msc_ms_counter.sv
`timescale 1ns/1ps
module tb_msc_ms_counter;

    localparam int DIV     = 8;
    localparam int SPACING = 64; // 8 ref periods of 40 ns / 5 ns bus period

    logic        clk = 1'b0, ref_clk = 1'b0;
    logic        rst = 1'b1, ref_rst = 1'b1;
    logic        bus_sel = 1'b1, bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h20;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always #20  ref_clk = ~ref_clk;

    msc_ms_counter #(.DIV_CYCLES(DIV)) dut (
        .clk, .rst, .ref_clk, .ref_rst,
        .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_wr = 1'b0;
        #0.5;
        d = bus_rdata;
        bus_addr = 8'h20;
    endtask

    // called on a negedge; the write takes effect at the next posedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h20;
    endtask

    task automatic wait_change(output logic [31:0] v, output int cyc);
        logic [31:0] prev;
        prev = bus_rdata;
        cyc  = 0;
        for (int i = 0; i < 4 * SPACING; i++) begin
            @(negedge clk);
            cyc++;
            if (bus_rdata !== prev) begin
                v = bus_rdata;
                return;
            end
        end
        v = bus_rdata;
        check("R2 timeout waiting for increment", 32'd0, 32'd1);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h20, d);
        check("R1 reset count", d, 32'h0);
    endtask

    task automatic t_rate;
        logic [31:0] v; int c;
        wait_change(v, c);
        check("R2 first increment", v, 32'd1);
        wait_change(v, c);
        check("R2 second increment", v, 32'd2);
        check("R3 spacing in bus cycles", 32'(c), 32'(SPACING));
    endtask

    task automatic t_alias_ops;
        logic [31:0] v, d; int c;
        wait_change(v, c);
        wr(8'h20, 32'h1234_5678);
        rd(8'h20, d); check("R4 load", d, 32'h1234_5678);
        wr(8'h24, 32'h0000_0F01);
        rd(8'h20, d); check("R5 set", d, 32'h1234_5F79);
        wr(8'h28, 32'h00FF_0000);
        rd(8'h20, d); check("R6 clear", d, 32'h1200_5F79);
        wr(8'h2C, 32'hFFFF_0000);
        rd(8'h20, d); check("R7 toggle", d, 32'hEDFF_5F79);
        wait_change(v, c);
        check("R2 increment after ops", v, 32'hEDFF_5F7A);
    endtask

    task automatic t_read_aliases;
        logic [31:0] v, d; int c;
        wait_change(v, c);
        rd(8'h24, d); check("R10 read set alias", d, v);
        rd(8'h28, d); check("R10 read clear alias", d, v);
        rd(8'h2C, d); check("R10 read toggle alias", d, v);
    endtask

    task automatic t_unmapped;
        logic [31:0] v, d; int c;
        wait_change(v, c);
        rd(8'h30, d); check("R11 unmapped read", d, 32'h0);
        rd(8'h21, d); check("R11 misaligned read", d, 32'h0);
        wr(8'h30, 32'hDEAD_BEEF);
        wr(8'h1C, 32'hDEAD_BEEF);
        rd(8'h20, d); check("R11 unmapped write ignored", d, v);
    endtask

    task automatic t_wrap;
        logic [31:0] v, d; int c;
        wait_change(v, c);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, d); check("R4 load all ones", d, 32'hFFFF_FFFF);
        wait_change(v, c);
        check("R8 wrap to zero", v, 32'h0);
    endtask

    task automatic t_collision;
        logic [31:0] v, d; int c;
        wait_change(v, c);
        repeat (SPACING - 1) @(negedge clk);
        wr(8'h20, 32'h0000_1000); // lands on the next tick's cycle
        repeat (10) @(negedge clk);
        rd(8'h20, d); check("R9 write wins, tick dropped", d, 32'h0000_1000);
        wait_change(v, c);
        check("R9 next tick counts from written value", v, 32'h0000_1001);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst = 1'b0; ref_rst = 1'b0;
        t_reset();
        t_rate();
        t_alias_ops();
        t_read_aliases();
        t_unmapped();
        t_wrap();
        t_collision();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule